// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block sends one character at a time on a single serial line with asynchronous start/stop framing. A control word sets the format of each frame. The character length runs from one to eight bits. A parity bit with odd or even sense can be added, and the frame ends with one or two stop bits. One mode inserts an extra address/data marker bit after the character, for multiprocessor links. The other, idle-line mode, leaves that bit out.

A character enters through a valid/ready handshake, together with an address flag. The block accepts a character only while it is idle. It captures the control word, the data and the flag at the moment of acceptance. Bit timing comes from an external one-cycle tick, and each frame bit lasts exactly one tick period. A loopback setting steers the frame onto an internal path that feeds a local receiver. In that mode the external line stays high.

Top module: `frame_tx`

## Requirements
- R1: Control bits [2:0] hold a length code n; the frame carries n+1 data bits, least significant first, and data bits above that length never reach the line.
- R2: The line idles high (1); every frame opens with a single low start bit, followed in turn by the data bits, the address marker (if any), the parity bit (if any) and the stop bits.
- R3: Control bit 7 clear gives one high stop bit; set gives two.
- R4: Control bit 5 set adds a parity bit. Control bit 6 picks the sense: 0 makes the count of ones over the covered bits plus parity odd, 1 makes it even. With bit 5 clear, no parity bit is sent.
- R5: Control bit 3 set (address mode) sends the captured address flag as one bit right after the data bits; with bit 3 clear no such bit exists.
- R6: Parity covers only the data bits inside the selected length, plus the address marker when address mode is on.
- R7: in_ready_o is high only while no frame is in progress; a character is taken when in_valid_i and in_ready_o are both high at a clock edge, and later changes of cfg_i, in_data_i or in_addr_i do not alter that frame.
- R8: After acceptance busy_o rises at once while the line stays high; each frame bit appears on the clock edge where tick_i is sampled high, holds until the next tick, and busy_o falls on the tick that ends the last stop bit.
- R9: Control bit 4 set (loopback) sends the frame on loop_o while line_o stays high; with it clear the frame goes on line_o and loop_o stays high.
- R10: After reset line_o and loop_o are high, busy_o is low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 8 | Frame format control word |
| in_valid_i | input | 1 | Character offered |
| in_data_i | input | 8 | Character data, right-justified |
| in_addr_i | input | 1 | Address marker value for address mode |
| in_ready_o | output | 1 | Block can take a character |
| tick_i | input | 1 | One-cycle bit-rate enable |
| line_o | output | 1 | External serial output |
| loop_o | output | 1 | Internal loopback serial path |
| busy_o | output | 1 | Frame in progress |

## Verification
Every result follows a known clock edge. busy_o and in_ready_o change on the edge that accepts a character. Frame bit k shows up on the edge of tick k+1 after acceptance, and busy_o falls on tick n+1 for a frame of n bits. The bench drives inputs and samples outputs on falling edges. Right after each tick it compares the active line with the expected bit. In the idle cycles between ticks it checks that the line has not moved. Tick spacing varies from every cycle to every fourth cycle, so a bit that lasts too long or too short is caught.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/frame_tx_rst_sync.sv
module frame_tx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/frame_tx_fmt.sv
// Builds the full frame, LSB (start bit) first, and its bit count.
module frame_tx_fmt #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3,
  parameter int FW     = 13,
  parameter int CNT_W  = 4
) (
  input  logic [LEN_W-1:0]  len_i,
  input  logic              addr_mode_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              two_stop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_i,
  output logic [FW-1:0]     frame_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             ones;
  logic [CNT_W-1:0] pos;

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    ones       = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i <= int'(len_i)) begin
        frame_o[1+i] = data_i[i];
        ones         = ones ^ data_i[i];
      end
    end
    pos = CNT_W'(len_i) + CNT_W'(2);
    if (addr_mode_i) begin
      frame_o[pos] = addr_i;
      ones         = ones ^ addr_i;
      pos          = pos + CNT_W'(1);
    end
    if (par_en_i) begin
      frame_o[pos] = par_even_i ? ones : ~ones;
      pos          = pos + CNT_W'(1);
    end
    count_o = pos + CNT_W'(1) + CNT_W'(two_stop_i);
  end
endmodule

// File: rtl/frame_tx_shift.sv
module frame_tx_shift
  import frame_tx_pkg::*;
#(
  parameter int FW    = 13,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [FW-1:0]    frame_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             txd_o,
  output logic             busy_o
);
  tx_state_e        st_q, st_d;
  logic [FW-1:0]    sr_q, sr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             txd_q, txd_d;

  always_comb begin
    st_d   = st_q;
    sr_d   = sr_q;
    left_d = left_q;
    txd_d  = txd_q;
    unique case (st_q)
      ST_IDLE: begin
        if (load_i) begin
          st_d   = ST_SEND;
          sr_d   = frame_i;
          left_d = count_i;
        end
      end
      ST_SEND: begin
        if (tick_i) begin
          if (left_q != '0) begin
            txd_d  = sr_q[0];
            sr_d   = {1'b1, sr_q[FW-1:1]};
            left_d = left_q - CNT_W'(1);
          end else begin
            txd_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sr_q   <= '1;
      left_q <= '0;
      txd_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      left_q <= left_d;
      txd_q  <= txd_d;
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = (st_q == ST_SEND);
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int DATA_W = 8
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [((DATA_W>1)?$clog2(DATA_W):1)+4:0]   cfg_i,
  input  logic                                       in_valid_i,
  input  logic [DATA_W-1:0]                          in_data_i,
  input  logic                                       in_addr_i,
  output logic                                       in_ready_o,
  input  logic                                       tick_i,
  output logic                                       line_o,
  output logic                                       loop_o,
  output logic                                       busy_o
);
  localparam int LEN_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int FW     = DATA_W + 5;
  localparam int CNT_W  = $clog2(FW + 1);
  localparam int B_ADDR = LEN_W;
  localparam int B_LOOP = LEN_W + 1;
  localparam int B_PEN  = LEN_W + 2;
  localparam int B_PEVN = LEN_W + 3;
  localparam int B_STOP = LEN_W + 4;

  logic             rst_sync_n;
  logic             accept;
  logic             busy;
  logic             txd;
  logic             loop_q;
  logic [FW-1:0]    frame;
  logic [CNT_W-1:0] count;

  frame_tx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  frame_tx_fmt #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .FW     (FW),
    .CNT_W  (CNT_W)
  ) u_fmt (
    .len_i       (cfg_i[LEN_W-1:0]),
    .addr_mode_i (cfg_i[B_ADDR]),
    .par_en_i    (cfg_i[B_PEN]),
    .par_even_i  (cfg_i[B_PEVN]),
    .two_stop_i  (cfg_i[B_STOP]),
    .data_i      (in_data_i),
    .addr_i      (in_addr_i),
    .frame_o     (frame),
    .count_o     (count)
  );

  frame_tx_shift #(
    .FW    (FW),
    .CNT_W (CNT_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (accept),
    .tick_i  (tick_i),
    .frame_i (frame),
    .count_i (count),
    .txd_o   (txd),
    .busy_o  (busy)
  );

  assign in_ready_o = rst_sync_n & ~busy;
  assign accept     = in_valid_i & in_ready_o;

  // Loopback choice is captured with the character.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  loop_q <= 1'b0;
    else if (accept)  loop_q <= cfg_i[B_LOOP];
  end

  assign line_o = loop_q ? 1'b1 : txd;
  assign loop_o = loop_q ? txd  : 1'b1;
  assign busy_o = busy;
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic tick_i,
  input logic line_o,
  input logic loop_o,
  input logic busy_o
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (line_o && loop_o));

  p_one_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o || loop_o));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> busy_o);

  p_hold_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> ($stable(line_o) && $stable(loop_o)));

  p_end_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> busy_o);
endmodule

bind frame_tx frame_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .tick_i     (tick_i),
  .line_o     (line_o),
  .loop_o     (loop_o),
  .busy_o     (busy_o)
);

// File: tb/frame_tx_tb_top.sv
module frame_tx_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] cfg_i;
  logic       in_valid_i;
  logic [7:0] in_data_i;
  logic       in_addr_i;
  logic       in_ready_o;
  logic       tick_i;
  logic       line_o;
  logic       loop_o;
  logic       busy_o;

  int    n_chk;
  int    n_fail;
  logic  exp_bits [0:15];
  string exp_tag  [0:15];
  int    exp_n;

  frame_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_i      (cfg_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_addr_i  (in_addr_i),
    .in_ready_o (in_ready_o),
    .tick_i     (tick_i),
    .line_o     (line_o),
    .loop_o     (loop_o),
    .busy_o     (busy_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Expected frame from the requirement text.
  function automatic void fill_exp(input logic [7:0] c, input logic [7:0] d, input logic a);
    int         nb;
    int         cnt;
    int         p;
    logic [7:0] m;
    nb  = int'(c[2:0]) + 1;
    m   = 8'((9'd1 << nb) - 9'd1);
    cnt = $countones(d & m);
    p   = 0;
    exp_bits[p] = 1'b0; exp_tag[p] = "R2"; p++;
    for (int i = 0; i < nb; i++) begin
      exp_bits[p] = d[i]; exp_tag[p] = "R1"; p++;
    end
    if (c[3]) begin
      exp_bits[p] = a; exp_tag[p] = "R5"; p++;
      cnt += int'(a);
    end
    if (c[5]) begin
      exp_bits[p] = c[6] ? cnt[0] : ~cnt[0];
      exp_tag[p]  = (c[3] || nb < 8) ? "R6" : "R4";
      p++;
    end
    exp_bits[p] = 1'b1; exp_tag[p] = "R3"; p++;
    if (c[7]) begin
      exp_bits[p] = 1'b1; exp_tag[p] = "R3"; p++;
    end
    exp_n = p;
  endfunction

  task automatic send(input logic [7:0] c, input logic [7:0] d, input logic a,
                      input int gap, input bit hold);
    logic lb;
    int   obs;
    lb = c[4];
    fill_exp(c, d, a);
    @(negedge clk);
    cfg_i = c; in_data_i = d; in_addr_i = a; in_valid_i = 1'b1; tick_i = 1'b0;
    @(negedge clk);
    chk("R8", int'(busy_o), 1, "busy after accept");
    chk("R7", int'(in_ready_o), 0, "ready while busy");
    chk("R8", int'(line_o & loop_o), 1, "line high before first tick");
    in_valid_i = hold;
    cfg_i = 8'($urandom); in_data_i = 8'($urandom); in_addr_i = 1'($urandom);
    for (int k = 0; k <= exp_n; k++) begin
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        if (k > 0) begin
          obs = lb ? int'(loop_o) : int'(line_o);
          chk("R8", obs, int'(exp_bits[k-1]), "bit held between ticks");
        end
      end
      if (k == exp_n) in_valid_i = 1'b0;
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      if (k < exp_n) begin
        obs = lb ? int'(loop_o) : int'(line_o);
        chk(exp_tag[k], obs, int'(exp_bits[k]), $sformatf("frame bit %0d", k));
        chk("R9", lb ? int'(line_o) : int'(loop_o), 1, "unused path high");
        chk("R7", int'(in_ready_o), 0, "ready low mid frame");
      end else begin
        chk("R8", int'(busy_o), 0, "busy drops after last stop");
        chk("R8", int'(line_o & loop_o), 1, "lines idle after frame");
        chk("R7", int'(in_ready_o), 1, "ready after frame");
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd24680));
    rst_n = 1'b0; cfg_i = '0; in_valid_i = 1'b0; in_data_i = '0;
    in_addr_i = 1'b0; tick_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", int'(line_o), 1, "line after reset");
    chk("R10", int'(loop_o), 1, "loop after reset");
    chk("R10", int'(busy_o), 0, "busy after reset");
    chk("R10", int'(in_ready_o), 1, "ready after reset");

    // Directed corners.
    send(8'b0000_0111, 8'hA5, 1'b0, 1, 1'b0);   // R1 8 bits, one stop, tick every cycle
    send(8'b1000_0000, 8'hFE, 1'b0, 2, 1'b0);   // R1 one bit, upper bits ignored; R3 two stops
    send(8'b0110_0000, 8'hFE, 1'b0, 3, 1'b0);   // R6 even parity over bit 0 only
    send(8'b0010_0010, 8'h07, 1'b0, 2, 1'b0);   // R4 odd parity, 3 bits
    send(8'b0110_1111, 8'h81, 1'b1, 2, 1'b1);   // R5 R6 addr bit in even parity, R7 held valid
    send(8'b0010_1111, 8'hFF, 1'b1, 4, 1'b0);   // R6 odd parity with addr bit
    send(8'b1001_0101, 8'h2C, 1'b0, 3, 1'b1);   // R9 loopback
    send(8'b0000_1011, 8'h05, 1'b0, 1, 1'b0);   // R5 addr flag zero

    for (int t = 0; t < 300; t++) begin
      send(8'($urandom), 8'($urandom), 1'($urandom),
           1 + int'($urandom % 4), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule